// File: doc/BRIEF.md
# Link Mode Resolver with Carrier Logic

This block picks the operating speed and duplex of one Ethernet PHY port, and from that choice it derives the carrier sense (CRS) and collision (COL) signals that go to the MAC. With auto-negotiation on, it compares the local ability word with a 16-bit partner ability word. Each time the partner word's valid strobe fires, it registers the best mode that both sides support. With auto-negotiation off, the result follows the manual speed and duplex bits.

The carrier stage then combines the resolved mode with the raw transmit-active and receive-active indications:
- In full duplex, collision is suppressed and carrier sense reflects reception only.
- In half duplex, carrier sense covers both directions and a collision is flagged when they overlap.
- When no mode is resolved, both signals stay low.

Link pulse generation, burst decoding, next pages and parallel detection sit outside this block.

Top module: `link_mode_resolver`

## Requirements
- R1: With auto-negotiation on, a strobed partner word resolves to the highest mode present in both ability words, ranked 100 Mb/s full (bit 8) over 100 Mb/s half (bit 7) over 10 Mb/s full (bit 6) over 10 Mb/s half (bit 5). Other bits have no effect. Encoding: `res_speed100`=1 means 100 Mb/s, `res_full`=1 means full duplex.
- R2: The result is registered. It appears one clock after `partner_vld` while `an_enable`=1, and it holds between strobes even when the partner word changes.
- R3: If no ability bit is shared, `res_valid` is 0, and `crs` and `col` stay 0 whatever the activity inputs are.
- R4: While `an_enable`=0, the result one clock later equals `man_speed100`/`man_full` with `res_valid`=1, and partner strobes have no effect.
- R5: A 0-to-1 change of `an_enable` clears the result (`res_valid`=0) one clock later, until the next partner strobe. A strobe in the same cycle as the change is loaded instead.
- R6: In resolved full duplex, `col`=0 and `crs` equals `rx_active`.
- R7: In resolved half duplex, `col` = `tx_active` AND `rx_active`, and `crs` = `tx_active` OR `rx_active`.
- R8: After reset, `res_valid`, `res_speed100`, `res_full`, `crs` and `col` are 0. With `an_enable` held at 1 through reset, the first partner strobe resolves without any further enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_abil | input | 16 | Local ability advertisement word |
| partner_abil | input | 16 | Partner ability word |
| partner_vld | input | 1 | Strobe: partner word is valid this cycle |
| an_enable | input | 1 | Auto-negotiation enable |
| man_speed100 | input | 1 | Manual speed, 1 = 100 Mb/s |
| man_full | input | 1 | Manual duplex, 1 = full |
| tx_active | input | 1 | Raw transmit activity |
| rx_active | input | 1 | Raw receive activity |
| res_speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| res_full | output | 1 | Resolved duplex, 1 = full |
| res_valid | output | 1 | A mode is resolved |
| crs | output | 1 | Carrier sense to the MAC |
| col | output | 1 | Collision to the MAC |

## Verification
The properties assume that `partner_vld` and the manual bits are synchronous and steady around each clock edge. They also assume the ability bits sit at the default positions 5 to 8, because the checker tests bit 8 directly. The stimulus changes every input only on the falling clock edge and keeps the default positions. Every table row pulses the strobe for exactly one cycle with `an_enable` already high, so each expected result depends on one strobe only.

// File: rtl/lmr_pkg.sv
// Package: shared types for the link mode resolver.
// Assumes: four ability levels, ranked from fastest/full to slowest/half.
package lmr_pkg;

    // Number of priority levels in the resolution ladder
    localparam int NUM_LEVELS = 4;

    // Resolved link result carried between the submodules
    typedef struct packed {
        logic valid;
        logic speed100;
        logic full;
    } link_res_t;

    // Rank index (0 = best) to speed bit
    function automatic logic level_speed100(input int lvl);
        return (lvl < 2);
    endfunction

    // Rank index (0 = best) to duplex bit
    function automatic logic level_full(input int lvl);
        return (lvl % 2 == 0);
    endfunction

endpackage

// File: rtl/lmr_priority_pick.sv
// Module: lmr_priority_pick
// Combinationally finds the best mode present in both ability words.
// Assumes: the bit positions are distinct and lie inside WORD_W.
module lmr_priority_pick
    import lmr_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int POS_10H  = 5,
    parameter int POS_10F  = 6,
    parameter int POS_100H = 7,
    parameter int POS_100F = 8
) (
    input  logic [WORD_W-1:0] local_word,
    input  logic [WORD_W-1:0] partner_word,
    output link_res_t         pick
);

    localparam int LVL_W = $clog2(NUM_LEVELS);

    // Rank index (0 = best) to bit position in the ability word
    function automatic int level_pos(input int lvl);
        case (lvl)
            0:       return POS_100F;
            1:       return POS_100H;
            2:       return POS_10F;
            default: return POS_10H;
        endcase
    endfunction

    logic [NUM_LEVELS-1:0] shared;

    // One AND per rank: the mode is offered by both sides
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        assign shared[g] = local_word[level_pos(g)] & partner_word[level_pos(g)];
    end

    logic [LVL_W-1:0] best_lvl;

    // Walk from worst to best so the best shared rank wins
    always_comb begin
        best_lvl = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (shared[l]) best_lvl = LVL_W'(l);
        end
    end

    // Map the winning rank onto the result fields
    always_comb begin
        pick.valid    = |shared;
        pick.speed100 = (|shared) & level_speed100(int'(best_lvl));
        pick.full     = (|shared) & level_full(int'(best_lvl));
    end

endmodule

// File: rtl/lmr_mode_reg.sv
// Module: lmr_mode_reg
// Holds the resolved mode: it loads a negotiated pick on a strobe,
// tracks the manual bits when negotiation is off, and clears on a
// rising enable edge.
// Assumes: synchronous inputs, synchronous active-low reset.
module lmr_mode_reg
    import lmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      an_enable,
    input  logic      partner_vld,
    input  link_res_t pick,
    input  logic      man_speed100,
    input  logic      man_full,
    output link_res_t res
);

    logic en_q;

    // Delayed enable, used to spot a 0-to-1 change
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= an_enable;
    end

    // Result register: manual > strobe load > clear on enable rise > hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (!an_enable) begin
            res <= '{valid: 1'b1, speed100: man_speed100, full: man_full};
        end else if (partner_vld) begin
            res <= pick;
        end else if (!en_q) begin
            res <= '0;
        end
    end

endmodule

// File: rtl/lmr_carrier_gen.sv
// Module: lmr_carrier_gen
// Derives carrier sense and collision from the resolved duplex and the
// raw activity indications.
// Assumes: activity inputs are already synchronous to clk.
module lmr_carrier_gen
    import lmr_pkg::*;
(
    input  link_res_t res,
    input  logic      tx_active,
    input  logic      rx_active,
    output logic      crs,
    output logic      col
);

    // Duplex-dependent carrier and collision; both are quiet when unresolved
    always_comb begin
        if (!res.valid) begin
            crs = 1'b0;
            col = 1'b0;
        end else if (res.full) begin
            crs = rx_active;
            col = 1'b0;
        end else begin
            crs = tx_active | rx_active;
            col = tx_active & rx_active;
        end
    end

endmodule

// File: rtl/link_mode_resolver.sv
// Module: link_mode_resolver (top)
// Resolves speed and duplex for one PHY port and produces CRS/COL.
// Assumes: the partner word is presented together with a one-cycle strobe.
module link_mode_resolver
    import lmr_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int POS_10H  = 5,
    parameter int POS_10F  = 6,
    parameter int POS_100H = 7,
    parameter int POS_100F = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] local_abil,
    input  logic [WORD_W-1:0] partner_abil,
    input  logic              partner_vld,
    input  logic              an_enable,
    input  logic              man_speed100,
    input  logic              man_full,
    input  logic              tx_active,
    input  logic              rx_active,
    output logic              res_speed100,
    output logic              res_full,
    output logic              res_valid,
    output logic              crs,
    output logic              col
);

    link_res_t pick;
    link_res_t res;

    lmr_priority_pick #(
        .WORD_W  (WORD_W),
        .POS_10H (POS_10H),
        .POS_10F (POS_10F),
        .POS_100H(POS_100H),
        .POS_100F(POS_100F)
    ) i_pick (
        .local_word  (local_abil),
        .partner_word(partner_abil),
        .pick        (pick)
    );

    lmr_mode_reg i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .an_enable   (an_enable),
        .partner_vld (partner_vld),
        .pick        (pick),
        .man_speed100(man_speed100),
        .man_full    (man_full),
        .res         (res)
    );

    lmr_carrier_gen i_carrier (
        .res      (res),
        .tx_active(tx_active),
        .rx_active(rx_active),
        .crs      (crs),
        .col      (col)
    );

    // Drive the resolved fields onto the ports
    assign res_speed100 = res.speed100;
    assign res_full     = res.full;
    assign res_valid    = res.valid;

endmodule

// File: rtl/link_mode_resolver_chk.sv
// Module: link_mode_resolver_chk
// Property checker bound to link_mode_resolver; it assumes the default
// ability bit positions.
module link_mode_resolver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] local_abil,
    input logic [15:0] partner_abil,
    input logic        partner_vld,
    input logic        an_enable,
    input logic        man_speed100,
    input logic        man_full,
    input logic        tx_active,
    input logic        rx_active,
    input logic        res_speed100,
    input logic        res_full,
    input logic        res_valid,
    input logic        crs,
    input logic        col
);

    // R1
    top_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_enable && partner_vld && local_abil[8] && partner_abil[8]
        |=> res_valid && res_speed100 && res_full);

    // R2
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_enable && $past(an_enable) && !partner_vld
        |=> $stable(res_valid) && $stable(res_speed100) && $stable(res_full));

    // R3
    quiet_unresolved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !crs && !col);

    // R4
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable |=> res_valid && (res_speed100 == $past(man_speed100))
                       && (res_full == $past(man_full)));

    // R5
    enable_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_enable) && !partner_vld |=> !res_valid);

    // R6
    full_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_full |-> !col && (crs == rx_active));

    // R7
    half_overlap_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_full && tx_active && rx_active |-> col && crs);

endmodule

bind link_mode_resolver link_mode_resolver_chk i_chk (.*);

// File: tb/test_link_mode_resolver.sv
module test_link_mode_resolver;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] local_abil;
    logic [15:0] partner_abil;
    logic        partner_vld;
    logic        an_enable;
    logic        man_speed100;
    logic        man_full;
    logic        tx_active;
    logic        rx_active;
    logic        res_speed100;
    logic        res_full;
    logic        res_valid;
    logic        crs;
    logic        col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_mode_resolver i_link_mode_resolver (
        .clk(clk), .rst_n(rst_n), .local_abil(local_abil),
        .partner_abil(partner_abil), .partner_vld(partner_vld),
        .an_enable(an_enable), .man_speed100(man_speed100), .man_full(man_full),
        .tx_active(tx_active), .rx_active(rx_active),
        .res_speed100(res_speed100), .res_full(res_full), .res_valid(res_valid),
        .crs(crs), .col(col)
    );

    // expected {valid, speed100, full}
    typedef struct packed {
        logic [15:0] loc;
        logic [15:0] par;
        logic [2:0]  exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'h01E0, 16'h01E0, 3'b111},   // R1 all shared -> 100 full
        '{16'h01E0, 16'h00E0, 3'b110},   // R1 -> 100 half
        '{16'h0160, 16'h00C0, 3'b101},   // R1 -> 10 full
        '{16'h0020, 16'h01E0, 3'b100},   // R1 -> 10 half
        '{16'h0100, 16'h0080, 3'b000},   // R3 disjoint
        '{16'h0180, 16'h0060, 3'b000},   // R3 disjoint
        '{16'h00A0, 16'h00A0, 3'b110},   // R1 -> 100 half
        '{16'h0140, 16'h0040, 3'b101},   // R1 -> 10 full
        '{16'h801F, 16'hFE1F, 3'b000}    // R1/R3 non-ability bits ignored
    };

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_carrier(input logic [2:0] r, input logic tx, input logic rx);
        if (!r[2])     return 2'b00;
        else if (r[0]) return {rx, 1'b0};
        else           return {tx | rx, tx & rx};
    endfunction

    task automatic strobe(input logic [15:0] loc, input logic [15:0] par);
        @(negedge clk);
        local_abil = loc; partner_abil = par; partner_vld = 1'b1;
        @(negedge clk);
        partner_vld = 1'b0;
    endtask

    task automatic sweep_carrier(input string req, input logic [2:0] r);
        for (int a = 0; a < 4; a++) begin
            tx_active = a[1]; rx_active = a[0];
            #1;
            chk(req, {1'b0, crs, col}, {1'b0, exp_carrier(r, a[1], a[0])});
        end
        tx_active = 1'b0; rx_active = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; local_abil = '0; partner_abil = '0; partner_vld = 1'b0;
        an_enable = 1'b1; man_speed100 = 1'b0; man_full = 1'b0;
        tx_active = 1'b0; rx_active = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state, enabled through reset
        chk("R8", {res_valid, res_speed100, res_full}, 3'b000);
        sweep_carrier("R8", 3'b000);

        // Table walk: R1, R2, R3, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            strobe(VECS[i].loc, VECS[i].par);
            chk("R1", {res_valid, res_speed100, res_full}, VECS[i].exp);
            if (!VECS[i].exp[2])      sweep_carrier("R3", VECS[i].exp);
            else if (VECS[i].exp[0])  sweep_carrier("R6", VECS[i].exp);
            else                      sweep_carrier("R7", VECS[i].exp);
        end

        // R2 hold: new word without strobe leaves result unchanged
        strobe(16'h01E0, 16'h0080);
        chk("R2", {res_valid, res_speed100, res_full}, 3'b110);
        partner_abil = 16'h0100; local_abil = 16'h0100;
        repeat (3) @(negedge clk);
        chk("R2", {res_valid, res_speed100, res_full}, 3'b110);

        // R4 manual mode, all four combinations, one clock after
        an_enable = 1'b0;
        for (int m = 0; m < 4; m++) begin
            man_speed100 = m[1]; man_full = m[0];
            @(negedge clk);
            chk("R4", {res_valid, res_speed100, res_full}, {1'b1, m[1], m[0]});
        end
        // R4 strobe ignored while disabled
        man_speed100 = 1'b0; man_full = 1'b0;
        strobe(16'h01E0, 16'h01E0);
        chk("R4", {res_valid, res_speed100, res_full}, 3'b100);
        sweep_carrier("R7", 3'b100);

        // R5 rising enable clears until strobe
        an_enable = 1'b1;
        @(negedge clk);
        chk("R5", {res_valid, res_speed100, res_full}, 3'b000);
        sweep_carrier("R5", 3'b000);
        repeat (2) @(negedge clk);
        chk("R5", {res_valid, res_speed100, res_full}, 3'b000);
        strobe(16'h0040, 16'h0040);
        chk("R5", {res_valid, res_speed100, res_full}, 3'b101);

        // R5 strobe in the same cycle as the rise is loaded
        an_enable = 1'b0;
        @(negedge clk);
        local_abil = 16'h0180; partner_abil = 16'h0100;
        partner_vld = 1'b1; an_enable = 1'b1;
        @(negedge clk);
        partner_vld = 1'b0;
        chk("R5", {res_valid, res_speed100, res_full}, 3'b111);

        // R8 reset again mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8", {res_valid, res_speed100, res_full}, 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule